// File: doc/BRIEF.md
# Processing-Element Local Task Controller

This controller sits inside one processing element. It stands between a task manager on the host side and a set of hardware task wrappers that all use one single-port local memory. The host talks to it through a small register port that it writes and polls. A start command names a wrapper by its task number. The controller gives the shared memory to that wrapper alone, pulses the wrapper's request line and waits for its acknowledge. It then posts a finish message with the same task number, which the host picks up by polling. The host moves on only when it sees these completion messages. Nothing in this block runs on a timer.

A running task is never interrupted. A start command that arrives while a task runs goes into a one-entry pending slot. It launches on the same clock edge on which the running task acknowledges. A second early command is dropped and raises an overrun flag. A start naming a task number that has no wrapper raises an error flag and launches nothing. A separate command register sends a transfer request to another element, and a sticky flag reports that the transfer has finished.

Top module: `pe_task_ctrl`

## Requirements
- R1: After a synchronous reset, `task_req`, `mem_sel` and `xfer_req` are zero. The status register and the finish register both read as zero.
- R2: A host write to address 0 (the start register) with the task number in bits [ID_W-1:0] reaches an idle controller. `task_req` then shows a one-cycle pulse on bit `id`. From the next cycle onward, `mem_sel` holds the one-hot value `1<<id` until that wrapper acknowledges.
- R3: At most one bit of `mem_sel` is ever set, so only one wrapper can use the memory at a time.
- R4: An acknowledge from a wrapper that does not hold `mem_sel` has no effect. The grant stays where it is and no finish message is posted.
- R5: When the selected wrapper acknowledges, `mem_sel` clears on that edge, unless a pending task launches then. The finish register at address 1 then reads bit 31 = 1 (valid) with the finished task number in bits [ID_W-1:0].
- R6: A valid start written while a task runs is held in the pending slot and status bit 1 is set. On the edge where the running task acknowledges, the held task launches: `task_req` pulses and `mem_sel` switches to it. The running task's grant is not disturbed before that edge.
- R7: A valid start written while a task runs and the pending slot is already full is dropped. It sets status bit 3 (overrun) and is never launched.
- R8: A start whose task number is NUM_TASKS or higher sets status bit 2 (bad id). It produces no request and no grant.
- R9: The finish valid bit clears when the host reads address 1 or writes address 1. The read returns the value from before the clear. A completion on the same edge as the clear wins, so the valid bit stays set and carries the new task number.
- R10: A write to address 2 while no transfer is running raises `xfer_req` and places the destination in bits [DST_W-1:0] on `xfer_dst`. Both hold until `xfer_done` is seen. On that edge `xfer_req` drops and status bit 5 (transfer finished) sets. Writes to address 2 while a transfer is running are ignored.
- R11: Status at address 3 reads busy in bit 0, pending in bit 1, bad id in bit 2, overrun in bit 3, transfer busy in bit 4 and transfer finished in bit 5. Writing a 1 to bit 2, 3 or 5 clears that flag. Read data appears on `reg_rdata` one cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_rd | input | 1 | Host register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| task_req | output | NUM_TASKS | One-cycle start pulse per wrapper |
| task_ack | input | NUM_TASKS | Completion acknowledge per wrapper |
| mem_sel | output | NUM_TASKS | One-hot memory grant |
| xfer_req | output | 1 | Inter-element transfer request, held until done |
| xfer_dst | output | DST_W | Transfer destination element |
| xfer_done | input | 1 | Transfer completion strobe |

## Verification
The bench goes after the edges where two events meet. One is a pending start that must launch on the very edge its predecessor acknowledges. A design that waits an extra idle cycle, or that drops the finish message for the old task, fails there. Another is a finish read that lands on the same edge as a new completion. A design where the clear beats the set loses a completion the host never sees. Stray acknowledges from wrappers that are not selected, out-of-range task numbers and a second transfer command while one is running are all sent on purpose. A design that posts false finishes, launches a wrapper that does not exist or retargets a running transfer is caught at the ports.

// File: rtl/pe_tc_pkg.sv
package pe_tc_pkg;
  localparam int REG_AW = 2;
  localparam logic [REG_AW-1:0] A_START  = 2'd0;
  localparam logic [REG_AW-1:0] A_FINISH = 2'd1;
  localparam logic [REG_AW-1:0] A_XFER   = 2'd2;
  localparam logic [REG_AW-1:0] A_STATUS = 2'd3;

  localparam int S_BUSY  = 0;
  localparam int S_PEND  = 1;
  localparam int S_BAD   = 2;
  localparam int S_OVR   = 3;
  localparam int S_XBUSY = 4;
  localparam int S_XFIN  = 5;
  localparam int STAT_W  = 6;
endpackage

// File: rtl/pe_grant_dec.sv
module pe_grant_dec #(
  parameter int NUM_TASKS = 4,
  parameter int ID_W      = 3
) (
  input  logic [ID_W-1:0]      id,
  output logic [NUM_TASKS-1:0] onehot,
  output logic                 ok
);
  for (genvar g = 0; g < NUM_TASKS; g++) begin : g_dec
    assign onehot[g] = (id == ID_W'(g));
  end
  assign ok = |onehot;
endmodule

// File: rtl/pe_task_seq.sv
module pe_task_seq #(
  parameter int NUM_TASKS = 4,
  parameter int ID_W      = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_stb,
  input  logic [ID_W-1:0]      start_id,
  input  logic                 fin_clr,
  input  logic                 bad_clr,
  input  logic                 ovr_clr,
  input  logic [NUM_TASKS-1:0] task_ack,
  output logic [NUM_TASKS-1:0] task_req,
  output logic [NUM_TASKS-1:0] mem_sel,
  output logic                 busy,
  output logic                 pend_v,
  output logic                 bad_err,
  output logic                 ovr_err,
  output logic                 fin_v,
  output logic [ID_W-1:0]      fin_id
);
  logic [ID_W-1:0]      cur_id, pend_id;
  logic [NUM_TASKS-1:0] start_oh, pend_oh;
  logic                 start_ok, pend_ok_unused;
  logic                 ack_hit, free_now, start_good;

  pe_grant_dec #(.NUM_TASKS(NUM_TASKS), .ID_W(ID_W)) u_dec_start (
    .id(start_id), .onehot(start_oh), .ok(start_ok));
  pe_grant_dec #(.NUM_TASKS(NUM_TASKS), .ID_W(ID_W)) u_dec_pend (
    .id(pend_id), .onehot(pend_oh), .ok(pend_ok_unused));

  assign ack_hit    = busy && |(task_ack & mem_sel);
  assign free_now   = !busy || ack_hit;
  assign start_good = start_stb && start_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      task_req <= '0;
      mem_sel  <= '0;
      busy     <= 1'b0;
      cur_id   <= '0;
      pend_v   <= 1'b0;
      pend_id  <= '0;
      bad_err  <= 1'b0;
      ovr_err  <= 1'b0;
      fin_v    <= 1'b0;
      fin_id   <= '0;
    end else begin
      task_req <= '0;
      if (fin_clr) fin_v <= 1'b0;
      if (bad_clr) bad_err <= 1'b0;
      if (ovr_clr) ovr_err <= 1'b0;
      if (ack_hit) begin
        fin_v  <= 1'b1;
        fin_id <= cur_id;
      end
      if (free_now) begin
        if (pend_v) begin
          busy     <= 1'b1;
          cur_id   <= pend_id;
          mem_sel  <= pend_oh;
          task_req <= pend_oh;
          pend_v   <= start_good;
          if (start_good) pend_id <= start_id;
        end else if (start_good) begin
          busy     <= 1'b1;
          cur_id   <= start_id;
          mem_sel  <= start_oh;
          task_req <= start_oh;
        end else begin
          busy    <= 1'b0;
          mem_sel <= '0;
        end
      end else if (start_good) begin
        if (!pend_v) begin
          pend_v  <= 1'b1;
          pend_id <= start_id;
        end else begin
          ovr_err <= 1'b1;
        end
      end
      if (start_stb && !start_ok) bad_err <= 1'b1;
    end
  end
endmodule

// File: rtl/pe_xfer_trk.sv
module pe_xfer_trk #(
  parameter int DST_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [DST_W-1:0] dst_in,
  input  logic             done,
  input  logic             fin_clr,
  output logic             xreq,
  output logic [DST_W-1:0] dst,
  output logic             xfin
);
  always_ff @(posedge clk) begin
    if (rst) begin
      xreq <= 1'b0;
      dst  <= '0;
      xfin <= 1'b0;
    end else begin
      if (fin_clr) xfin <= 1'b0;
      if (xreq) begin
        if (done) begin
          xreq <= 1'b0;
          xfin <= 1'b1;
        end
      end else if (go) begin
        xreq <= 1'b1;
        dst  <= dst_in;
      end
    end
  end
endmodule

// File: rtl/pe_task_ctrl.sv
module pe_task_ctrl
  import pe_tc_pkg::*;
#(
  parameter int NUM_TASKS = 4,
  parameter int ID_W      = 3,
  parameter int DST_W     = 4,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [REG_AW-1:0]    reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  output logic [NUM_TASKS-1:0] task_req,
  input  logic [NUM_TASKS-1:0] task_ack,
  output logic [NUM_TASKS-1:0] mem_sel,
  output logic                 xfer_req,
  output logic [DST_W-1:0]     xfer_dst,
  input  logic                 xfer_done
);
  logic              wr_start, wr_fin, wr_xfer, wr_stat, rd_fin;
  logic              busy, pend_v, bad_err, ovr_err, fin_v, xfin;
  logic [ID_W-1:0]   fin_id;
  logic [STAT_W-1:0] stat;
  logic              unused_wdata;

  assign wr_start = reg_wr && (reg_addr == A_START);
  assign wr_fin   = reg_wr && (reg_addr == A_FINISH);
  assign wr_xfer  = reg_wr && (reg_addr == A_XFER);
  assign wr_stat  = reg_wr && (reg_addr == A_STATUS);
  assign rd_fin   = reg_rd && (reg_addr == A_FINISH);
  assign unused_wdata = ^reg_wdata;

  pe_task_seq #(.NUM_TASKS(NUM_TASKS), .ID_W(ID_W)) u_seq (
    .clk(clk), .rst(rst),
    .start_stb(wr_start), .start_id(reg_wdata[ID_W-1:0]),
    .fin_clr(wr_fin || rd_fin),
    .bad_clr(wr_stat && reg_wdata[S_BAD]),
    .ovr_clr(wr_stat && reg_wdata[S_OVR]),
    .task_ack(task_ack), .task_req(task_req), .mem_sel(mem_sel),
    .busy(busy), .pend_v(pend_v), .bad_err(bad_err), .ovr_err(ovr_err),
    .fin_v(fin_v), .fin_id(fin_id));

  pe_xfer_trk #(.DST_W(DST_W)) u_xfer (
    .clk(clk), .rst(rst),
    .go(wr_xfer), .dst_in(reg_wdata[DST_W-1:0]), .done(xfer_done),
    .fin_clr(wr_stat && reg_wdata[S_XFIN]),
    .xreq(xfer_req), .dst(xfer_dst), .xfin(xfin));

  always_comb begin
    stat          = '0;
    stat[S_BUSY]  = busy;
    stat[S_PEND]  = pend_v;
    stat[S_BAD]   = bad_err;
    stat[S_OVR]   = ovr_err;
    stat[S_XBUSY] = xfer_req;
    stat[S_XFIN]  = xfin;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      reg_rdata <= '0;
      case (reg_addr)
        A_FINISH: begin
          reg_rdata[DATA_W-1] <= fin_v;
          reg_rdata[ID_W-1:0] <= fin_id;
        end
        A_XFER:   reg_rdata[DST_W-1:0]  <= xfer_dst;
        A_STATUS: reg_rdata[STAT_W-1:0] <= stat;
        default:  reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/pe_task_ctrl_chk.sv
module pe_task_ctrl_chk #(
  parameter int NUM_TASKS = 4,
  parameter int ID_W      = 3,
  parameter int DST_W     = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 wr_start,
  input logic [ID_W-1:0]      wr_id,
  input logic [NUM_TASKS-1:0] task_req,
  input logic [NUM_TASKS-1:0] task_ack,
  input logic [NUM_TASKS-1:0] mem_sel,
  input logic                 fin_v,
  input logic                 xfer_req,
  input logic                 xfer_done,
  input logic [DST_W-1:0]     xfer_dst
);
  p_sel_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(mem_sel));

  p_req_in_grant_r2: assert property (@(posedge clk) disable iff (rst)
    (task_req & ~mem_sel) == '0);

  p_grant_held_r6: assert property (@(posedge clk) disable iff (rst)
    (mem_sel != '0 && (task_ack & mem_sel) == '0) |=> mem_sel == $past(mem_sel));

  p_fin_on_ack_r5: assert property (@(posedge clk) disable iff (rst)
    ((task_ack & mem_sel) != '0) |=> fin_v);

  p_fin_needs_ack_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(fin_v) |-> $past((task_ack & mem_sel) != '0));

  p_bad_id_no_req_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_start && (32'(wr_id) >= 32'(NUM_TASKS)) && mem_sel == '0) |=> task_req == '0);

  p_xfer_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (xfer_req && !xfer_done) |=> (xfer_req && $stable(xfer_dst)));
endmodule

bind pe_task_ctrl pe_task_ctrl_chk #(
  .NUM_TASKS(NUM_TASKS), .ID_W(ID_W), .DST_W(DST_W)
) u_chk (
  .clk(clk), .rst(rst),
  .wr_start(wr_start), .wr_id(reg_wdata[ID_W-1:0]),
  .task_req(task_req), .task_ack(task_ack), .mem_sel(mem_sel),
  .fin_v(fin_v), .xfer_req(xfer_req), .xfer_done(xfer_done), .xfer_dst(xfer_dst)
);

// File: tb/pe_task_ctrl_tb.sv
`timescale 1ns/1ps
module pe_task_ctrl_tb;
  localparam int N  = 4;
  localparam int IW = 3;
  localparam int DW = 4;
  localparam int BW = 32;

  logic          clk = 0;
  logic          rst = 1;
  logic          reg_wr = 0, reg_rd = 0;
  logic [1:0]    reg_addr = 0;
  logic [BW-1:0] reg_wdata = 0;
  logic [BW-1:0] reg_rdata;
  logic [N-1:0]  task_req, task_ack = 0, mem_sel;
  logic          xfer_req, xfer_done = 0;
  logic [DW-1:0] xfer_dst;

  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  pe_task_ctrl #(.NUM_TASKS(N), .ID_W(IW), .DST_W(DW), .DATA_W(BW)) u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .task_req(task_req),
    .task_ack(task_ack), .mem_sel(mem_sel), .xfer_req(xfer_req),
    .xfer_dst(xfer_dst), .xfer_done(xfer_done));

  function automatic logic [N-1:0] exp_oh(input int id);
    return N'(1) << id;
  endfunction
  function automatic logic [BW-1:0] exp_fin(input bit v, input int id);
    logic [BW-1:0] w = '0;
    w[BW-1] = v;
    w[IW-1:0] = IW'(id);
    return w;
  endfunction
  function automatic logic [BW-1:0] exp_stat(input bit b, p, bad, ovr, xb, xf);
    return BW'({xf, xb, ovr, bad, p, b});
  endfunction

  task automatic chk(input bit ok, input string req, input logic [BW-1:0] act, exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [BW-1:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0; reg_wdata = 0;
  endtask
  task automatic rd(input logic [1:0] a, output logic [BW-1:0] v);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; v = reg_rdata;
  endtask
  task automatic ack(input logic [N-1:0] m);
    @(negedge clk); task_ack = m;
    @(negedge clk); task_ack = 0;
  endtask

  initial begin
    #400000;
    fails++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [BW-1:0] v;
    void'($urandom(32'h1234_abcd));
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state
    chk(mem_sel == 0 && task_req == 0 && xfer_req == 0, "R1 outputs", {task_req, mem_sel}, 0);
    rd(2'd3, v); chk(v == 0, "R1 status", v, 0);
    rd(2'd1, v); chk(v == 0, "R1 finish", v, 0);

    // R2 launch on wrapper 2
    wr(2'd0, 2);
    chk(task_req == exp_oh(2), "R2 req pulse", task_req, exp_oh(2));
    chk(mem_sel == exp_oh(2), "R2 grant", mem_sel, exp_oh(2));
    @(negedge clk);
    chk(task_req == 0, "R2 pulse one cycle", task_req, 0);
    chk(mem_sel == exp_oh(2), "R2 grant held", mem_sel, exp_oh(2));
    // R4 stray ack
    ack(exp_oh(1));
    chk(mem_sel == exp_oh(2), "R4 grant kept", mem_sel, exp_oh(2));
    rd(2'd1, v); chk(v == exp_fin(0, 0), "R4 no finish", v, exp_fin(0, 0));
    // R5 completion
    ack(exp_oh(2));
    chk(mem_sel == 0, "R5 grant drop", mem_sel, 0);
    rd(2'd1, v); chk(v == exp_fin(1, 2), "R5 finish word", v, exp_fin(1, 2));
    rd(2'd1, v); chk(v == exp_fin(0, 2), "R9 read clears", v, exp_fin(0, 2));

    // R6 / R7 pending and overrun
    wr(2'd0, 1);
    wr(2'd0, 3);
    wr(2'd0, 0);
    chk(mem_sel == exp_oh(1), "R6 running untouched", mem_sel, exp_oh(1));
    rd(2'd3, v); chk(v == exp_stat(1, 1, 0, 1, 0, 0), "R7 status overrun", v, exp_stat(1, 1, 0, 1, 0, 0));
    ack(exp_oh(1));
    chk(mem_sel == exp_oh(3), "R6 pending launch grant", mem_sel, exp_oh(3));
    chk(task_req == exp_oh(3), "R6 pending launch req", task_req, exp_oh(3));
    rd(2'd1, v); chk(v == exp_fin(1, 1), "R6 finish of first", v, exp_fin(1, 1));
    ack(exp_oh(3));
    chk(mem_sel == 0, "R7 dropped never runs", mem_sel, 0);
    rd(2'd1, v); chk(v == exp_fin(1, 3), "R6 finish of held", v, exp_fin(1, 3));
    wr(2'd3, 32'h8);
    rd(2'd3, v); chk(v == 0, "R11 overrun cleared", v, 0);

    // R8 bad id
    wr(2'd0, 5);
    chk(task_req == 0 && mem_sel == 0, "R8 nothing launched", {task_req, mem_sel}, 0);
    rd(2'd3, v); chk(v == exp_stat(0, 0, 1, 0, 0, 0), "R8 bad flag", v, exp_stat(0, 0, 1, 0, 0, 0));
    wr(2'd3, 32'h4);
    rd(2'd3, v); chk(v == 0, "R11 bad cleared", v, 0);

    // R9 completion coincident with read clear
    wr(2'd0, 2); ack(exp_oh(2));
    wr(2'd0, 0);
    @(negedge clk); reg_rd = 1; reg_addr = 2'd1; task_ack = exp_oh(0);
    @(negedge clk); reg_rd = 0; task_ack = 0; v = reg_rdata;
    chk(v == exp_fin(1, 2), "R9 old value returned", v, exp_fin(1, 2));
    rd(2'd1, v); chk(v == exp_fin(1, 0), "R9 set wins over clear", v, exp_fin(1, 0));
    wr(2'd0, 1); ack(exp_oh(1));
    wr(2'd1, 0);
    rd(2'd1, v); chk(v == exp_fin(0, 1), "R9 write clears", v, exp_fin(0, 1));

    // R10 transfer
    wr(2'd2, 5);
    chk(xfer_req == 1 && xfer_dst == 5, "R10 request", {xfer_req, xfer_dst}, {1'b1, 4'd5});
    wr(2'd2, 2);
    chk(xfer_dst == 5, "R10 second command ignored", xfer_dst, 5);
    rd(2'd3, v); chk(v == exp_stat(0, 0, 0, 0, 1, 0), "R11 xfer busy", v, exp_stat(0, 0, 0, 0, 1, 0));
    @(negedge clk); xfer_done = 1;
    @(negedge clk); xfer_done = 0;
    chk(xfer_req == 0, "R10 request drops", xfer_req, 0);
    rd(2'd3, v); chk(v == exp_stat(0, 0, 0, 0, 0, 1), "R10 finished flag", v, exp_stat(0, 0, 0, 0, 0, 1));
    wr(2'd3, 32'h20);
    rd(2'd3, v); chk(v == 0, "R11 xfer flag cleared", v, 0);

    // random single-task rounds (R2 R4 R5)
    for (int i = 0; i < 30; i++) begin
      int id  = $urandom_range(0, N - 1);
      int dly = $urandom_range(1, 4);
      wr(2'd0, BW'(id));
      chk(task_req == exp_oh(id), "R2 random req", task_req, exp_oh(id));
      repeat (dly) @(negedge clk);
      ack(exp_oh((id + 1) % N));
      chk(mem_sel == exp_oh(id), "R4 random stray", mem_sel, exp_oh(id));
      ack(exp_oh(id));
      chk(mem_sel == 0, "R5 random drop", mem_sel, 0);
      rd(2'd1, v); chk(v == exp_fin(1, id), "R5 random finish", v, exp_fin(1, id));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule